// File: doc/BRIEF.md
# Four-Moduli Residue-to-Binary Converter

This block turns a residue-number-system value held as four residues back into an ordinary unsigned binary integer. The moduli are 2^n-1, 2^n, 2^n+1 and 2^(n+1)+1, where n is an odd parameter. The block sits at the exit of a residue-domain arithmetic pipeline. Each residue arrives on its own bus, already reduced below its modulus, and the binary result leaves on one bus.

The conversion has two levels of mixed-radix steps. First, the pair (2^n-1, 2^n+1) is merged into a residue modulo 2^(2n)-1. In parallel, the pair (2^n, 2^(n+1)+1) is merged into a residue modulo 2^n·(2^(n+1)+1). A second mixed-radix step then joins those two partial results. Every step is chosen so that it needs only plain binary adders and end-around-carry adders, which work modulo 2^k-1. Constant scaling is done with shifts in the binary domain and with bit rotations in the modulo 2^k-1 domain. No arithmetic modulo 2^k+1 appears.

The full range is M = (2^(2n)-1)·(2^(2n+1)+2^n). This is slightly above 2^(4n+1), so the output carries 4n+2 bits. A parameter selects between a purely combinational path and one output register.

Top module: `rns4_rev_conv`

## Requirements
- R1: For every integer X in [0, M), applying the four residues X mod (2^n+1), X mod (2^n-1), X mod 2^n and X mod (2^(n+1)+1) yields bin_o equal to X.
- R2: bin_o is 4n+2 bits wide. The largest value, X = M-1, is reproduced exactly, and bin_o never reaches M.
- R3: The low n bits of bin_o always equal the residue presented for modulus 2^n.
- R4: All-zero residues give bin_o equal to zero.
- R5: With REG_OUT=1, bin_o takes the converted value at the rising clock edge after the inputs are applied. It holds that value while the inputs change between edges.
- R6: With REG_OUT=1, a low level on rst_ni clears bin_o to zero at once, without waiting for a clock edge. bin_o stays zero while rst_ni is low.
- R7: With REG_OUT=0, bin_o follows the inputs combinationally, with no clock edge needed.
- R8: The residue for 2^n+1 may take its largest value, 2^n, which has only its top bit set. That value is converted correctly.
- R9: Values whose intermediate mixed-radix digit comes out as the all-ones pattern of an end-around-carry sum are converted correctly, because that pattern is taken as zero. This covers multiples of 2^(2n)-1, of 2^n-1 and of 2^n+1.
- R10: Elaboration fails for an even n or for n below 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| res_p1_i | input | n+1 | Residue modulo 2^n+1 |
| res_m1_i | input | n | Residue modulo 2^n-1 |
| res_p0_i | input | n | Residue modulo 2^n |
| res_q_i | input | n+2 | Residue modulo 2^(n+1)+1 |
| bin_o | output | 4n+2 | Reconstructed unsigned binary value |

## Verification
The bench builds two copies of the block at the same time.

The first copy uses n=3 without the output register. Its range has only 8568 values, so every residue combination that can occur is applied, including every carry and fold case in the end-around-carry adders.

The second copy uses n=5 with the output register. A strided sweep, the range ends and chosen multiples of the intermediate moduli reach the wider datapath and its longer rotation chain. The same copy also shows register timing, holding between edges and asynchronous clearing.

// File: rtl/rns4_pkg.sv
package rns4_pkg;

  // modular inverse by extended Euclid, evaluated at elaboration
  function automatic longint inv_mod(input longint a, input longint m);
    longint t, nt, r, nr, q, tmp;
    t  = 0;
    nt = 1;
    r  = m;
    nr = a % m;
    while (nr != 0) begin
      q   = r / nr;
      tmp = t - q * nt;
      t   = nt;
      nt  = tmp;
      tmp = r - q * nr;
      r   = nr;
      nr  = tmp;
    end
    if (t < 0) t = t + m;
    return t;
  endfunction

  function automatic longint full_range(input int n);
    longint ma, mb;
    ma = (longint'(1) << (2 * n)) - 1;
    mb = (longint'(1) << (2 * n + 1)) + (longint'(1) << n);
    return ma * mb;
  endfunction

endpackage

// File: rtl/eac_add.sv
module eac_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  logic [W:0] raw_w;

  assign raw_w = {1'b0, a_i} + {1'b0, b_i};
  // carry wraps back into bit 0; cannot overflow a second time
  assign s_o   = raw_w[W-1:0] + {{(W-1){1'b0}}, raw_w[W]};
endmodule

// File: rtl/rns4_pair_lo.sv
module rns4_pair_lo #(
  parameter int N = 5
) (
  input  logic [N:0]     x_p1_i,
  input  logic [N-1:0]   x_m1_i,
  output logic [2*N-1:0] x_o
);
  logic [N-1:0] p1_fold_w, diff_w, dig_raw_w, dig_w;

  // reduce the (2^n+1) residue modulo 2^n-1: 2^n folds to 1
  eac_add #(.W(N)) u_fold (
    .a_i (x_p1_i[N-1:0]),
    .b_i ({{(N-1){1'b0}}, x_p1_i[N]}),
    .s_o (p1_fold_w)
  );

  eac_add #(.W(N)) u_sub (
    .a_i (x_m1_i),
    .b_i (~p1_fold_w),
    .s_o (diff_w)
  );

  // inverse of (2^n+1) mod (2^n-1) is 2^(n-1): rotate right by one
  assign dig_raw_w = {diff_w[0], diff_w[N-1:1]};
  assign dig_w     = (&dig_raw_w) ? '0 : dig_raw_w;

  assign x_o = {{(N-1){1'b0}}, x_p1_i}
             + {dig_w, {N{1'b0}}}
             + {{N{1'b0}}, dig_w};
endmodule

// File: rtl/rns4_pair_hi.sv
module rns4_pair_hi #(
  parameter int N = 5
) (
  input  logic [N-1:0]   x_p0_i,
  input  logic [N+1:0]   x_q_i,
  output logic [2*N+1:0] x_o
);
  logic [N-1:0] dig_w;

  // (2^(n+1)+1) mod 2^n is 1, so the digit is a truncated difference
  assign dig_w = x_p0_i - x_q_i[N-1:0];

  assign x_o = {{N{1'b0}}, x_q_i}
             + {1'b0, dig_w, {(N+1){1'b0}}}
             + {{(N+2){1'b0}}, dig_w};
endmodule

// File: rtl/rns4_merge.sv
module rns4_merge
  import rns4_pkg::*;
#(
  parameter int N = 5
) (
  input  logic [2*N-1:0] xa_i,
  input  logic [2*N+1:0] xb_i,
  output logic [2*N-1:0] dig_o,
  output logic [4*N+1:0] x_o
);
  localparam int      W     = 2 * N;
  localparam int      OW    = 4 * N + 2;
  localparam longint  MA    = (longint'(1) << W) - 1;
  localparam longint  MB_RD = (longint'(1) << N) + 2;
  localparam logic [W-1:0] INV_C = W'(inv_mod(MB_RD, MA));

  logic [W-1:0] xb_fold_w, diff_w;
  logic [W-1:0] acc_w [W+1];

  eac_add #(.W(W)) u_fold (
    .a_i (xb_i[W-1:0]),
    .b_i ({{(W-2){1'b0}}, xb_i[W+1:W]}),
    .s_o (xb_fold_w)
  );

  eac_add #(.W(W)) u_sub (
    .a_i (xa_i),
    .b_i (~xb_fold_w),
    .s_o (diff_w)
  );

  // constant multiply mod 2^W-1 as a sum of rotations
  assign acc_w[0] = '0;
  for (genvar j = 0; j < W; j++) begin : g_term
    if (INV_C[j]) begin : g_add
      logic [W-1:0] rot_w;
      assign rot_w = (diff_w << j) | (diff_w >> (W - j));
      eac_add #(.W(W)) u_acc (
        .a_i (acc_w[j]),
        .b_i (rot_w),
        .s_o (acc_w[j+1])
      );
    end else begin : g_skip
      assign acc_w[j+1] = acc_w[j];
    end
  end

  assign dig_o = (&acc_w[W]) ? '0 : acc_w[W];

  assign x_o = {{(OW-W-2){1'b0}}, xb_i}
             + {1'b0, dig_o, {(W+1){1'b0}}}
             + {{(N+2){1'b0}}, dig_o, {N{1'b0}}};
endmodule

// File: rtl/rns4_rev_conv.sv
module rns4_rev_conv #(
  parameter int N       = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N:0]     res_p1_i,
  input  logic [N-1:0]   res_m1_i,
  input  logic [N-1:0]   res_p0_i,
  input  logic [N+1:0]   res_q_i,
  output logic [4*N+1:0] bin_o
);
  // R10: only odd n from 3 up keep 2^n+2 invertible mod 2^(2n)-1
  if ((N % 2) == 0 || N < 3) begin : g_bad_n
    $error("rns4_rev_conv: N must be odd and at least 3");
  end

  logic [2*N-1:0] xa_w;
  logic [2*N+1:0] xb_w;
  logic [2*N-1:0] dig_w;
  logic [4*N+1:0] conv_w;

  rns4_pair_lo #(.N(N)) u_lo (
    .x_p1_i (res_p1_i),
    .x_m1_i (res_m1_i),
    .x_o    (xa_w)
  );

  rns4_pair_hi #(.N(N)) u_hi (
    .x_p0_i (res_p0_i),
    .x_q_i  (res_q_i),
    .x_o    (xb_w)
  );

  rns4_merge #(.N(N)) u_mrg (
    .xa_i  (xa_w),
    .xb_i  (xb_w),
    .dig_o (dig_w),
    .x_o   (conv_w)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bin_o <= '0;
      else         bin_o <= conv_w;
    end
  end else begin : g_comb
    assign bin_o = conv_w;
  end
endmodule

// File: rtl/rns4_rev_conv_chk.sv
module rns4_rev_conv_chk
  import rns4_pkg::*;
#(
  parameter int N       = 5,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [N-1:0]   res_p0_i,
  input logic [4*N+1:0] bin_o,
  input logic [2*N-1:0] xa_w,
  input logic [2*N+1:0] xb_w,
  input logic [2*N-1:0] dig_w
);
  localparam longint MA = (longint'(1) << (2 * N)) - 1;
  localparam longint MB = (longint'(1) << (2 * N + 1)) + (longint'(1) << N);
  localparam longint MV = full_range(N);

  assert_pair_lo_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    64'(xa_w) < MA);

  assert_pair_hi_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    64'(xb_w) < MB);

  assert_digit_norm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&dig_w));

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    64'(bin_o) < MV);

  if (REG_OUT) begin : g_reg_chk
    assert_low_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> bin_o[N-1:0] == $past(res_p0_i));

    assert_reset_clear_R6: assert property (@(posedge clk_i)
      !rst_ni |-> bin_o == '0);
  end else begin : g_comb_chk
    assert_low_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bin_o[N-1:0] == res_p0_i);
  end
endmodule

bind rns4_rev_conv rns4_rev_conv_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .res_p0_i (res_p0_i),
  .bin_o    (bin_o),
  .xa_w     (xa_w),
  .xb_w     (xb_w),
  .dig_w    (dig_w)
);

// File: tb/rns4_rev_conv_tb.sv
module rns4_rev_conv_tb;
  localparam int CLK_PERIOD = 10;
  localparam longint M3 = 64'd8568;
  localparam longint M5 = 64'd2127840;

  logic clk   = 1'b0;
  logic rst_n = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [3:0]  a_p1 = '0;
  logic [2:0]  a_m1 = '0;
  logic [2:0]  a_p0 = '0;
  logic [4:0]  a_q  = '0;
  logic [13:0] a_out;

  logic [5:0]  b_p1 = '0;
  logic [4:0]  b_m1 = '0;
  logic [4:0]  b_p0 = '0;
  logic [6:0]  b_q  = '0;
  logic [21:0] b_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  rns4_rev_conv #(.N(3), .REG_OUT(1'b0)) u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .res_p1_i (a_p1), .res_m1_i (a_m1), .res_p0_i (a_p0), .res_q_i (a_q),
    .bin_o (a_out)
  );

  rns4_rev_conv #(.N(5), .REG_OUT(1'b1)) u_dut_reg (
    .clk_i (clk), .rst_ni (rst_n),
    .res_p1_i (b_p1), .res_m1_i (b_m1), .res_p0_i (b_p0), .res_q_i (b_q),
    .bin_o (b_out)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_a(input longint x);
    a_p1 = 4'(x % 9);
    a_m1 = 3'(x % 7);
    a_p0 = 3'(x % 8);
    a_q  = 5'(x % 17);
  endtask

  task automatic drive_b(input longint x);
    b_p1 = 6'(x % 33);
    b_m1 = 5'(x % 31);
    b_p0 = 5'(x % 32);
    b_q  = 7'(x % 65);
  endtask

  // R6: output cleared while reset is low, then R5 load after release
  task automatic t_reset();
    drive_b(12345);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6 reset state", longint'(b_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 first load", longint'(b_out), 12345);
  endtask

  // R4
  task automatic t_zero();
    @(negedge clk);
    drive_a(0);
    drive_b(0);
    #1;
    chk("R4 zero comb", longint'(a_out), 0);
    @(negedge clk);
    chk("R4 zero reg", longint'(b_out), 0);
  endtask

  // R1, R3: every value of the n=3 range
  task automatic t_sweep3();
    for (longint x = 0; x < M3; x++) begin
      @(negedge clk);
      drive_a(x);
      #1;
      chk("R1 sweep n3", longint'(a_out), x);
      if ((x % 64) == 5) chk("R3 low bits n3", longint'(a_out) % 8, x % 8);
    end
  endtask

  // R7: no clock edge between stimulus and sample
  task automatic t_comb();
    for (int i = 0; i < 6; i++) begin
      @(posedge clk);
      #1;
      drive_a(longint'(i) * 1409 + 3);
      #1;
      chk("R7 comb follow", longint'(a_out), longint'(i) * 1409 + 3);
    end
  endtask

  // R2, R8: range ends and top residue 2^n for modulus 2^n+1
  task automatic t_edges();
    @(negedge clk);
    drive_a(M3 - 1);
    drive_b(M5 - 1);
    #1;
    chk("R2 max n3", longint'(a_out), M3 - 1);
    @(negedge clk);
    chk("R2 max n5", longint'(b_out), M5 - 1);
    drive_a(8 + 9 * 400);
    drive_b(32 + 33 * 1000);
    #1;
    chk("R8 top residue n3", longint'(a_out), 8 + 9 * 400);
    @(negedge clk);
    chk("R8 top residue n5", longint'(b_out), 32 + 33 * 1000);
    chk("R3 low bits n5", longint'(b_out) % 32, (32 + 33 * 1000) % 32);
  endtask

  // R1, R5: strided sweep of n=5 with one-cycle latency and hold
  task automatic t_sweep5();
    longint prev = 32 + 33 * 1000;
    for (longint x = 0; x < M5; x += 307) begin
      @(negedge clk);
      chk("R1 sweep n5", longint'(b_out), prev);
      drive_b(x);
      #1;
      if ((x % 3070) == 0) chk("R5 hold", longint'(b_out), prev);
      prev = x;
    end
    @(negedge clk);
    chk("R1 sweep n5 last", longint'(b_out), prev);
  endtask

  // R9: multiples of the intermediate moduli
  task automatic t_multiples();
    for (int j = 1; j <= 20; j++) begin
      longint vals [4];
      vals[0] = longint'(j) * 1023;
      vals[1] = longint'(j) * 31 * 977;
      vals[2] = longint'(j) * 33 * 511;
      vals[3] = longint'(j) * 63;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        drive_b(vals[k]);
        @(negedge clk);
        chk("R9 multiple n5", longint'(b_out), vals[k]);
      end
      @(negedge clk);
      drive_a(vals[3]);
      #1;
      chk("R9 multiple n3", longint'(a_out), vals[3]);
    end
  endtask

  // R6: asynchronous clear between edges
  task automatic t_async_reset();
    @(negedge clk);
    drive_b(777777);
    @(posedge clk);
    #2;
    chk("R5 value before reset", longint'(b_out), 777777);
    rst_n = 1'b0;
    #1;
    chk("R6 async clear", longint'(b_out), 0);
    @(posedge clk);
    #1;
    chk("R6 held in reset", longint'(b_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reload after reset", longint'(b_out), 777777);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    t_reset();
    t_zero();
    t_comb();
    t_edges();
    t_sweep3();
    t_sweep5();
    t_multiples();
    t_async_reset();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule